// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

A bank of independent hardware semaphores shared by several bus masters over a set of parallel 32-bit register ports. Each port carries a 4-bit master identifier beside the address and data. A master takes a semaphore by writing its own identifier into that semaphore's word and then reading the word back. If the low nibble matches its identifier, the claim succeeded. Otherwise the nibble names the master that holds it. Writing zero gives the semaphore back, but only the holder may do so.

A mode register selects between a polled protocol (bit 0 clear) and an interrupt protocol (bit 0 set). In the interrupt protocol, every release raises a pending flag for that semaphore. A single write of 0xFFFF to the flag register clears every flag. All ops in one cycle are judged against the owner values held at the start of that cycle. When several ports claim the same free semaphore in one cycle, the lowest-numbered port wins.

Top module: `hsem_bank`

## Requirements
- R1: After reset, every semaphore reads 0 (free), the mode register reads 0, and the flag register reads 0.
- R2: A write to a free semaphore whose data bits [3:0] equal the writer's nonzero master ID, with the whole word nonzero, makes that ID the owner. A read returns the owner in bits [3:0] and zeros above. A nonzero write whose bits [3:0] differ from the writer's ID is ignored.
- R3: Semaphore i sits at byte offset 0x08 + 4*i, the mode register at 0x00, and the flag register at 0x90. Address bits [1:0] are ignored. Reads of any other offset (for example 0x04 and 0x88) return 0.
- R4: A claim write to a semaphore held by another master is ignored, and the owner field keeps its value.
- R5: Writing 0 frees a semaphore only when the writer's master ID equals the current owner. A zero write from any other master is ignored.
- R6: When several ports claim the same free semaphore in one cycle, the lowest port index wins. A release and a claim in the same cycle both see the owner from the start of that cycle.
- R7: Bit 0 of the mode register is read/write, and bits [31:1] read 0. When several ports write it in one cycle, the lowest port index wins.
- R8: With mode bit 0 set, a successful release of semaphore i sets bit i of the flag register. With mode bit 0 clear, releases set no flag.
- R9: A write to 0x90 with data bits [15:0] equal to 0xFFFF clears all flags. Any other write to 0x90 leaves the flags unchanged.
- R10: A read request returns its data, with the read-valid output high, in the cycle after the request. The data reflects state before any write accepted in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_req_i | input | NP | Per-port access request |
| port_we_i | input | NP | Per-port write enable (0 = read) |
| port_addr_i | input | NP*AW | Per-port byte address |
| port_wdata_i | input | NP*32 | Per-port write data |
| port_mid_i | input | NP*4 | Per-port master identifier |
| port_rdata_o | output | NP*32 | Per-port registered read data |
| port_rvalid_o | output | NP | Per-port read data valid |

## Verification
A write takes effect at the clock edge that closes its request cycle. A read presented in any later cycle therefore sees the write, and the read data arrives one cycle after the read request. Flags change on the same edge as the release that sets them, and the clear-all write acts on the same edge as its request. The bench drives every request on a falling edge and holds it through one rising edge. It samples read data on the next falling edge, so each compared value was registered by exactly one edge after its request. The same-cycle contention case places both ports' writes in a single request cycle and reads the loser's port afterwards.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  localparam int DATA_W   = 32;
  localparam int ID_W     = 4;
  localparam int CTRL_OFS = 'h00;
  localparam int SEM_OFS  = 'h08;
  localparam int FLAG_OFS = 'h90;
  localparam int MAX_SEM  = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_SEM  = 2'd2,
    SEL_FLAG = 2'd3
  } sel_e;
endpackage

// File: rtl/hsem_decode.sv
module hsem_decode
  import hsem_pkg::*;
#(
  parameter int AW = 8,
  parameter int NS = 32,
  localparam int IW = $clog2(NS),
  localparam int WW = AW - 2
) (
  input  logic [AW-1:0] addr_i,
  output sel_e          sel_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [WW-1:0] CTRL_W  = WW'(CTRL_OFS >> 2);
  localparam logic [WW-1:0] FLAG_W  = WW'(FLAG_OFS >> 2);
  localparam logic [WW-1:0] SEM_LO  = WW'(SEM_OFS >> 2);
  localparam logic [WW-1:0] SEM_HI  = WW'((SEM_OFS >> 2) + NS);

  logic [WW-1:0] word;
  logic [WW-1:0] rel;
  logic          unused_lsb;

  assign word       = addr_i[AW-1:2];
  assign rel        = word - SEM_LO;
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (word == CTRL_W) begin
      sel_o = SEL_CTRL;
    end else if (word == FLAG_W) begin
      sel_o = SEL_FLAG;
    end else if (word >= SEM_LO && word < SEM_HI) begin
      sel_o = SEL_SEM;
      idx_o = rel[IW-1:0];
    end
  end
endmodule

// File: rtl/hsem_cell.sv
module hsem_cell
  import hsem_pkg::*;
#(
  parameter int NP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NP-1:0]     hit_i,
  input  logic [NP-1:0]     zero_i,
  input  logic [NP*ID_W-1:0] wid_i,
  input  logic [NP*ID_W-1:0] mid_i,
  output logic [ID_W-1:0]   owner_o,
  output logic              rel_o
);
  logic [ID_W-1:0] owner_q, owner_d;
  logic [NP-1:0]   claim_ok, rel_ok;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      claim_ok[p] = hit_i[p] && !zero_i[p] && (owner_q == '0)
                    && (mid_i[p*ID_W +: ID_W] != '0)
                    && (wid_i[p*ID_W +: ID_W] == mid_i[p*ID_W +: ID_W]);
      rel_ok[p]   = hit_i[p] && zero_i[p] && (owner_q != '0)
                    && (owner_q == mid_i[p*ID_W +: ID_W]);
    end
  end

  // claims only act on a free cell, releases only on a held one: never both
  always_comb begin
    owner_d = owner_q;
    if (|rel_ok) begin
      owner_d = '0;
    end else begin
      for (int p = NP - 1; p >= 0; p--) begin
        if (claim_ok[p]) owner_d = mid_i[p*ID_W +: ID_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= '0;
    else         owner_q <= owner_d;
  end

  assign owner_o = owner_q;
  assign rel_o   = |rel_ok;
endmodule

// File: rtl/hsem_rport.sv
module hsem_rport
  import hsem_pkg::*;
#(
  parameter int NS = 32,
  localparam int IW = $clog2(NS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  sel_e                sel_i,
  input  logic [IW-1:0]       idx_i,
  input  logic [NS*ID_W-1:0]  owners_i,
  input  logic                mode_i,
  input  logic [NS-1:0]       flags_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o
);
  logic [DATA_W-1:0] flag_word;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    flag_word = '0;
    flag_word[NS-1:0] = flags_i;
  end

  always_comb begin
    rd_d = '0;
    unique case (sel_i)
      SEL_CTRL: rd_d[0]      = mode_i;
      SEL_SEM:  rd_d[ID_W-1:0] = owners_i[idx_i*ID_W +: ID_W];
      SEL_FLAG: rd_d         = flag_word;
      default:  rd_d         = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_d;
    end
  end
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
  import hsem_pkg::*;
#(
  parameter int NP = 2,
  parameter int NS = 32,
  parameter int AW = 8,
  localparam int IW = $clog2(NS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NP-1:0]        port_req_i,
  input  logic [NP-1:0]        port_we_i,
  input  logic [NP*AW-1:0]     port_addr_i,
  input  logic [NP*DATA_W-1:0] port_wdata_i,
  input  logic [NP*ID_W-1:0]   port_mid_i,
  output logic [NP*DATA_W-1:0] port_rdata_o,
  output logic [NP-1:0]        port_rvalid_o
);
  sel_e                sel   [NP];
  logic [IW-1:0]       idx   [NP];
  logic [NP-1:0]       wr, rd, wzero;
  logic [NP*ID_W-1:0]  wnib;
  logic [NP-1:0]       sem_hit [NS];
  logic [NS*ID_W-1:0]  owner_q;
  logic [NS-1:0]       rel_v;
  logic [NS-1:0]       flag_q;
  logic                mode_q, mode_d;
  logic                clr_all;

  for (genvar p = 0; p < NP; p++) begin : g_port
    hsem_decode #(.AW(AW), .NS(NS)) u_dec (
      .addr_i (port_addr_i[p*AW +: AW]),
      .sel_o  (sel[p]),
      .idx_o  (idx[p])
    );
    assign wr[p]    = port_req_i[p] & port_we_i[p];
    assign rd[p]    = port_req_i[p] & ~port_we_i[p];
    assign wzero[p] = (port_wdata_i[p*DATA_W +: DATA_W] == '0);
    assign wnib[p*ID_W +: ID_W] = port_wdata_i[p*DATA_W +: ID_W];
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < NP; p++) begin
        sem_hit[s][p] = wr[p] && (sel[p] == SEL_SEM) && (idx[p] == IW'(s));
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_sem
    hsem_cell #(.NP(NP)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (sem_hit[s]),
      .zero_i  (wzero),
      .wid_i   (wnib),
      .mid_i   (port_mid_i),
      .owner_o (owner_q[s*ID_W +: ID_W]),
      .rel_o   (rel_v[s])
    );
  end

  // mode register: lowest port written last so it wins
  always_comb begin
    mode_d  = mode_q;
    clr_all = 1'b0;
    for (int p = NP - 1; p >= 0; p--) begin
      if (wr[p] && sel[p] == SEL_CTRL) mode_d = port_wdata_i[p*DATA_W];
      if (wr[p] && sel[p] == SEL_FLAG &&
          port_wdata_i[p*DATA_W +: 16] == 16'hFFFF) clr_all = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      flag_q <= (flag_q & ~{NS{clr_all}}) | (rel_v & {NS{mode_q}});
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    hsem_rport #(.NS(NS)) u_rport (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_i     (rd[p]),
      .sel_i    (sel[p]),
      .idx_i    (idx[p]),
      .owners_i (owner_q),
      .mode_i   (mode_q),
      .flags_i  (flag_q),
      .rdata_o  (port_rdata_o[p*DATA_W +: DATA_W]),
      .rvalid_o (port_rvalid_o[p])
    );
  end
endmodule

// File: rtl/hsem_bank_chk.sv
module hsem_bank_chk
  import hsem_pkg::*;
#(
  parameter int NP = 2,
  parameter int NS = 32,
  parameter int AW = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NP-1:0]        port_req_i,
  input logic [NP-1:0]        port_we_i,
  input logic [NP*AW-1:0]     port_addr_i,
  input logic [NP*DATA_W-1:0] port_rdata_o,
  input logic [NP-1:0]        port_rvalid_o,
  input logic [NS*ID_W-1:0]   owner_q,
  input logic [NS-1:0]        flag_q,
  input logic                 mode_q
);
  for (genvar s = 0; s < NS; s++) begin : g_s
    // R4/R5: a held semaphore can only go back to free, never straight to another owner
    a_r4_no_steal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(owner_q[s*ID_W +: ID_W]) != '0 &&
       owner_q[s*ID_W +: ID_W] != $past(owner_q[s*ID_W +: ID_W]))
      |-> owner_q[s*ID_W +: ID_W] == '0);
    // R2: a free semaphore only becomes held after some port wrote
    a_r2_claim_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(owner_q[s*ID_W +: ID_W]) == '0 && owner_q[s*ID_W +: ID_W] != '0)
      |-> $past(|(port_req_i & port_we_i)));
    // R8: flags only rise while interrupt mode is selected
    a_r8_flag_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[s]) |-> $past(mode_q));
  end

  // R7: upper bits of the mode register read as zero
  a_r7_mode_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rvalid_o[0] && $past(port_req_i[0] && !port_we_i[0] &&
                               port_addr_i[AW-1:2] == '0))
    |-> port_rdata_o[DATA_W-1:1] == '0);

  // R3: offset 0x04 is unmapped and reads zero
  a_r3_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rvalid_o[0] && $past(port_req_i[0] && !port_we_i[0] &&
                               port_addr_i[AW-1:2] == (AW-2)'(1)))
    |-> port_rdata_o[DATA_W-1:0] == '0);
endmodule

bind hsem_bank hsem_bank_chk #(.NP(NP), .NS(NS), .AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .port_req_i    (port_req_i),
  .port_we_i     (port_we_i),
  .port_addr_i   (port_addr_i),
  .port_rdata_o  (port_rdata_o),
  .port_rvalid_o (port_rvalid_o),
  .owner_q       (owner_q),
  .flag_q        (flag_q),
  .mode_q        (mode_q)
);

// File: tb/hsem_bank_test.sv
module hsem_bank_test;
  localparam int NP = 2;
  localparam int NS = 32;
  localparam int AW = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NP-1:0]     req = '0, we = '0;
  logic [NP*AW-1:0]  addr = '0;
  logic [NP*32-1:0]  wdata = '0;
  logic [NP*4-1:0]   mid = '0;
  logic [NP*32-1:0]  rdata;
  logic [NP-1:0]     rvalid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hsem_bank #(.NP(NP), .NS(NS), .AW(AW)) uut (
    .clk_i (clk), .rst_ni (rst_ni),
    .port_req_i (req), .port_we_i (we), .port_addr_i (addr),
    .port_wdata_i (wdata), .port_mid_i (mid),
    .port_rdata_o (rdata), .port_rvalid_o (rvalid)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic set_port(input int p, input bit w, input logic [7:0] a,
                          input logic [31:0] d, input logic [3:0] m);
    req[p] = 1'b1; we[p] = w;
    addr[p*AW +: AW] = a; wdata[p*32 +: 32] = d; mid[p*4 +: 4] = m;
  endtask

  task automatic idle();
    req = '0; we = '0; addr = '0; wdata = '0; mid = '0;
  endtask

  task automatic wr(input int p, input logic [7:0] a, input logic [31:0] d,
                    input logic [3:0] m);
    @(negedge clk); idle(); set_port(p, 1'b1, a, d, m);
    @(negedge clk); idle();
  endtask

  task automatic rd(input int p, input logic [7:0] a, input logic [3:0] m,
                    output logic [31:0] v);
    @(negedge clk); idle(); set_port(p, 1'b0, a, 32'h0, m);
    @(negedge clk); idle();
    v = rdata[p*32 +: 32];
    n_chk++;
    if (rvalid[p] !== 1'b1) begin
      n_fail++;
      $display("FAIL R10: rvalid actual %b expected 1", rvalid[p]);
    end
  endtask

  function automatic logic [7:0] sem_a(input int i);
    return 8'(8'h08 + 4 * i);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 8'h00, 4'd1, v); chk("R1 mode", v, 0);
    rd(0, sem_a(0), 4'd1, v); chk("R1 sem0", v, 0);
    rd(1, sem_a(31), 4'd2, v); chk("R1 sem31", v, 0);
    rd(0, 8'h90, 4'd1, v); chk("R1 flags", v, 0);
  endtask

  task automatic t_claim_release();
    logic [31:0] v;
    wr(0, sem_a(3), 32'h1, 4'd1);
    rd(0, sem_a(3), 4'd1, v); chk("R2 claim", v, 32'h1);
    rd(1, sem_a(3) | 8'h3, 4'd2, v); chk("R3 lsb ignored", v, 32'h1);
    wr(1, sem_a(3), 32'h2, 4'd2);
    rd(1, sem_a(3), 4'd2, v); chk("R4 held", v, 32'h1);
    wr(1, sem_a(3), 32'h0, 4'd2);
    rd(0, sem_a(3), 4'd1, v); chk("R5 foreign release", v, 32'h1);
    wr(0, sem_a(3), 32'h0, 4'd1);
    rd(1, sem_a(3), 4'd2, v); chk("R5 owner release", v, 32'h0);
    wr(0, sem_a(4), 32'h3, 4'd1);
    rd(0, sem_a(4), 4'd1, v); chk("R2 id mismatch", v, 32'h0);
    wr(1, sem_a(5), 32'hA0A0_000C, 4'd12);
    rd(1, sem_a(5), 4'd12, v); chk("R2 upper bits", v, 32'hC);
    wr(0, sem_a(5), 32'h0, 4'd12);
    rd(0, sem_a(5), 4'd12, v); chk("R5 release", v, 32'h0);
  endtask

  task automatic t_contention();
    logic [31:0] v;
    @(negedge clk); idle();
    set_port(0, 1'b1, sem_a(31), 32'h5, 4'd5);
    set_port(1, 1'b1, sem_a(31), 32'h9, 4'd9);
    @(negedge clk); idle();
    rd(1, sem_a(31), 4'd9, v); chk("R6 low port wins", v, 32'h5);
    // release and claim in one cycle: claim sees the cell still held
    @(negedge clk); idle();
    set_port(0, 1'b1, sem_a(31), 32'h0, 4'd5);
    set_port(1, 1'b1, sem_a(31), 32'h9, 4'd9);
    @(negedge clk); idle();
    rd(0, sem_a(31), 4'd5, v); chk("R6 same-cycle release", v, 32'h0);
    wr(1, sem_a(0), 32'h7, 4'd7);
    wr(0, sem_a(1), 32'h6, 4'd6);
    rd(0, sem_a(0), 4'd6, v); chk("R3 sem0 independent", v, 32'h7);
    rd(1, sem_a(1), 4'd7, v); chk("R3 sem1 independent", v, 32'h6);
    rd(0, 8'h88, 4'd1, v); chk("R3 unmapped 0x88", v, 0);
    rd(0, 8'h04, 4'd1, v); chk("R3 unmapped 0x04", v, 0);
  endtask

  task automatic t_mode_flags();
    logic [31:0] v;
    wr(0, 8'h00, 32'hFFFF_FFFF, 4'd1);
    rd(1, 8'h00, 4'd2, v); chk("R7 mode bit0 only", v, 32'h1);
    @(negedge clk); idle();
    set_port(0, 1'b1, 8'h00, 32'h1, 4'd1);
    set_port(1, 1'b1, 8'h00, 32'h0, 4'd2);
    @(negedge clk); idle();
    rd(0, 8'h00, 4'd1, v); chk("R7 low port wins", v, 32'h1);
    wr(0, sem_a(7), 32'h1, 4'd1);
    wr(0, sem_a(7), 32'h0, 4'd1);
    rd(0, 8'h90, 4'd1, v); chk("R8 flag set", v, 32'h80);
    wr(1, 8'h90, 32'h0000_1234, 4'd2);
    rd(1, 8'h90, 4'd2, v); chk("R9 partial clear ignored", v, 32'h80);
    wr(1, 8'h90, 32'h0000_FFFF, 4'd2);
    rd(0, 8'h90, 4'd1, v); chk("R9 clear all", v, 32'h0);
    wr(0, 8'h00, 32'h0, 4'd1);
    rd(0, 8'h00, 4'd1, v); chk("R7 mode cleared", v, 32'h0);
    wr(1, sem_a(9), 32'h2, 4'd2);
    wr(1, sem_a(9), 32'h0, 4'd2);
    rd(0, 8'h90, 4'd1, v); chk("R8 polled no flag", v, 32'h0);
  endtask

  task automatic t_read_order();
    logic [31:0] v;
    // R10: a read in the same cycle as another port's claim sees the old owner
    @(negedge clk); idle();
    set_port(0, 1'b0, sem_a(12), 32'h0, 4'd1);
    set_port(1, 1'b1, sem_a(12), 32'h4, 4'd4);
    @(negedge clk); idle();
    chk("R10 pre-write view", rdata[31:0], 32'h0);
    rd(0, sem_a(12), 4'd1, v); chk("R10 post-write view", v, 32'h4);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R10 rvalid low when idle", {31'b0, rvalid[0]}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_claim_release();
    t_contention();
    t_mode_flags();
    t_read_order();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule